// File: doc/BRIEF.md
# 16-bit Execute Unit with Condition Flag

This block is the execute stage of a small 16-bit processor. Each cycle in which `valid_i` is high, it takes a 5-bit operation code and two 16-bit operands. One clock edge later it presents a registered result, with write strobes that tell the register file which destinations to update.

The block supports the following operation groups:
- bitwise logic;
- logical shifts and rotates;
- add, subtract and multiply;
- an unsigned divide that returns both quotient and remainder.

It also holds four status bits. Three are arithmetic flags: zero, carry and overflow. The fourth is a separate condition bit. Only compare operations and condition-control operations write the condition bit. Branch logic elsewhere consumes it.

A divide whose divisor is zero writes nothing. Instead it raises a one-cycle fault pulse, which the surrounding core turns into exception number zero. The register file, memory access and branching are outside this block.

Top module: `xu16_exec`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after it rises, all outputs are 0: results, strobes, fault and the four flags.
- R2: An operation sampled with `valid_i` high shows its effect after exactly one rising clock edge. Opcodes are: 0 none, 1 NOT, 2 AND, 3 OR, 4 XOR, 5 NOR, 6 shift right, 7 shift left, 8 rotate right, 9 rotate left, 10 add, 11 subtract, 12 multiply, 13 divide, 14 cmp-eq, 15 cmp-gt, 16 cmp-lt, 17 cmp-ge, 18 cmp-le, 19 cond-invert, 20 cond-set, 21 cond-clear, 22 cond-from-overflow, 23 cond-from-zero, 24 cond-from-carry. Three cases behave as a nop: `valid_i` low, opcode 0, and opcodes 25 to 31. A nop clears both strobes, both results and the fault, and holds all flags. A result output reads 0 whenever its strobe is low.
- R3: The five bitwise operations (opcodes 1 to 5) write A-op-B, or ~A for NOT, to `res_a_o` with `wr_a_o`. They set zero to (result == 0) and hold carry, overflow and the condition bit.
- R4: Shifts and rotates use only B[3:0] as the count. Shift right is logical and updates only the zero flag.
- R5: Shift left by n updates zero and carry. For n > 0, carry is A[16-n], the last bit shifted out. For n = 0, carry is cleared and the result equals A.
- R6: Rotate right and rotate left write the rotated value and leave all four flags unchanged.
- R7: Add writes (A+B) mod 2^16. Carry is the carry out of bit 15, overflow is signed two's-complement overflow, and zero follows the result. The condition bit is held.
- R8: Subtract writes (A-B) mod 2^16. Carry is set when A < B unsigned (a borrow occurred), overflow is signed overflow of A-B, and zero follows the result.
- R9: Multiply writes the low 16 bits of the unsigned product. Carry and overflow are both set exactly when the product exceeds 0xFFFF. Zero and the condition bit are held.
- R10: Divide with B != 0 writes the unsigned quotient A/B to `res_a_o` with `wr_a_o`, and the remainder A%B to `res_b_o` with `wr_b_o`. All flags are held.
- R11: Divide with B == 0 pulses `fault_o` for one cycle. Both strobes stay low and all flags are held.
- R12: Compares set the condition bit from an unsigned comparison of A against B (==, >, <, >=, <=) and hold the other three flags and both strobes.
- R13: The condition-control operations invert, set or clear the condition bit, or copy overflow, zero or carry into it. Other flags are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand (divisor, shift count) |
| res_a_o | output | 16 | Primary result (quotient for divide) |
| res_b_o | output | 16 | Remainder of a divide |
| wr_a_o | output | 1 | Write strobe for `res_a_o` |
| wr_b_o | output | 1 | Write strobe for `res_b_o` |
| fault_o | output | 1 | Divide-by-zero fault pulse |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / borrow flag |
| ovf_o | output | 1 | Signed overflow flag |
| cond_o | output | 1 | Condition bit |

## Verification
Random opcodes drawn from all 32 codes are mixed with random operands. About one divisor in eight is forced to zero, so the divide and fault paths are both exercised. The undefined codes and `valid_i`-low cycles separate a true nop from a stray write.

Directed cases target the edges where similar rules disagree:
- add at 0xFFFF+1 versus 0x7FFF+1 separates carry from overflow;
- subtract at 0-1 versus 0x8000-1 separates borrow from overflow;
- shift-left counts of 0, 16 and 19 show that the count is masked and that carry comes from the right bit;
- compares on equal operands separate the strict relations from the non-strict ones.

// File: rtl/xu16_pkg.sv
`timescale 1ns/1ps
package xu16_pkg;

    localparam int XU_W = 16;

    typedef enum logic [4:0] {
        XU_NOP  = 5'd0,
        XU_NOT  = 5'd1,
        XU_AND  = 5'd2,
        XU_OR   = 5'd3,
        XU_XOR  = 5'd4,
        XU_NOR  = 5'd5,
        XU_SHR  = 5'd6,
        XU_SHL  = 5'd7,
        XU_ROR  = 5'd8,
        XU_ROL  = 5'd9,
        XU_ADD  = 5'd10,
        XU_SUB  = 5'd11,
        XU_MUL  = 5'd12,
        XU_DIV  = 5'd13,
        XU_CEQ  = 5'd14,
        XU_CGT  = 5'd15,
        XU_CLT  = 5'd16,
        XU_CGE  = 5'd17,
        XU_CLE  = 5'd18,
        XU_CINV = 5'd19,
        XU_CSET = 5'd20,
        XU_CCLR = 5'd21,
        XU_COV  = 5'd22,
        XU_CZF  = 5'd23,
        XU_CCA  = 5'd24
    } xu_op_e;

    typedef struct packed {
        logic zf;
        logic ca;
        logic ov;
        logic cf;
    } xu_flags_t;

endpackage

// File: rtl/xu16_bitops.sv
`timescale 1ns/1ps
// Bitwise logic, logical shifts and rotates.
module xu16_bitops
    import xu16_pkg::*;
#(
    parameter int W = XU_W
) (
    input  xu_op_e        op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic [W-1:0]  res_o,
    output logic          hit_o,
    output xu_flags_t     upd_o,
    output xu_flags_t     val_o
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] amt;
    logic [W:0]      shl_wide;
    logic [2*W-1:0]  ror_wide;
    logic [2*W-1:0]  rol_wide;

    assign amt      = b_i[SH_W-1:0];
    assign shl_wide = {1'b0, a_i} << amt;
    assign ror_wide = {a_i, a_i} >> amt;
    assign rol_wide = {a_i, a_i} << amt;

    always_comb begin
        res_o = '0;
        hit_o = 1'b1;
        upd_o = '0;
        val_o = '0;
        unique case (op_i)
            XU_NOT: res_o = ~a_i;
            XU_AND: res_o = a_i & b_i;
            XU_OR:  res_o = a_i | b_i;
            XU_XOR: res_o = a_i ^ b_i;
            XU_NOR: res_o = ~(a_i | b_i);
            XU_SHR: res_o = a_i >> amt;
            XU_SHL: begin
                res_o    = shl_wide[W-1:0];
                upd_o.ca = 1'b1;
                val_o.ca = shl_wide[W];
            end
            XU_ROR: res_o = ror_wide[W-1:0];
            XU_ROL: res_o = rol_wide[2*W-1:W];
            default: hit_o = 1'b0;
        endcase
        if (hit_o && op_i != XU_ROR && op_i != XU_ROL) begin
            upd_o.zf = 1'b1;
            val_o.zf = (res_o == '0);
        end
    end
endmodule

// File: rtl/xu16_arith.sv
`timescale 1ns/1ps
// Add, subtract and multiply with carry/overflow generation.
module xu16_arith
    import xu16_pkg::*;
#(
    parameter int W = XU_W
) (
    input  xu_op_e        op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic [W-1:0]  res_o,
    output logic          hit_o,
    output xu_flags_t     upd_o,
    output xu_flags_t     val_o
);
    logic [W:0]     sum;
    logic [W:0]     dif;
    logic [2*W-1:0] prod;
    logic           prod_hi;

    assign sum     = {1'b0, a_i} + {1'b0, b_i};
    assign dif     = {1'b0, a_i} - {1'b0, b_i};
    assign prod    = a_i * b_i;
    assign prod_hi = |prod[2*W-1:W];

    always_comb begin
        res_o = '0;
        hit_o = 1'b1;
        upd_o = '0;
        val_o = '0;
        unique case (op_i)
            XU_ADD: begin
                res_o    = sum[W-1:0];
                upd_o.zf = 1'b1;
                upd_o.ca = 1'b1;
                upd_o.ov = 1'b1;
                val_o.zf = (sum[W-1:0] == '0);
                val_o.ca = sum[W];
                val_o.ov = (a_i[W-1] == b_i[W-1]) && (sum[W-1] != a_i[W-1]);
            end
            XU_SUB: begin
                res_o    = dif[W-1:0];
                upd_o.zf = 1'b1;
                upd_o.ca = 1'b1;
                upd_o.ov = 1'b1;
                val_o.zf = (dif[W-1:0] == '0);
                val_o.ca = dif[W];
                val_o.ov = (a_i[W-1] != b_i[W-1]) && (dif[W-1] != a_i[W-1]);
            end
            XU_MUL: begin
                res_o    = prod[W-1:0];
                upd_o.ca = 1'b1;
                upd_o.ov = 1'b1;
                val_o.ca = prod_hi;
                val_o.ov = prod_hi;
            end
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/xu16_divider.sv
`timescale 1ns/1ps
// Unrolled restoring divider: one compare/subtract stage per quotient bit.
module xu16_divider
    import xu16_pkg::*;
#(
    parameter int W = XU_W
) (
    input  xu_op_e        op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic [W-1:0]  quo_o,
    output logic [W-1:0]  rem_o,
    output logic          ok_o,
    output logic          fault_o
);
    logic [W-1:0] part [W+1];
    logic [W-1:0] q;

    assign part[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic [W:0] trial;
        logic [W:0] diff;
        assign trial = {part[i], a_i[W-1-i]};
        assign diff  = trial - {1'b0, b_i};
        assign q[W-1-i]  = ~diff[W];
        assign part[i+1] = diff[W] ? trial[W-1:0] : diff[W-1:0];
    end

    logic is_div;
    logic zero_div;

    assign is_div   = (op_i == XU_DIV);
    assign zero_div = (b_i == '0);
    assign ok_o     = is_div && !zero_div;
    assign fault_o  = is_div && zero_div;
    assign quo_o    = ok_o ? q : '0;
    assign rem_o    = ok_o ? part[W] : '0;
endmodule

// File: rtl/xu16_cond.sv
`timescale 1ns/1ps
// Unsigned compares and condition-bit control.
module xu16_cond
    import xu16_pkg::*;
#(
    parameter int W = XU_W
) (
    input  xu_op_e        op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  xu_flags_t     flags_i,
    output logic          upd_o,
    output logic          val_o
);
    logic eq;
    logic gt;

    assign eq = (a_i == b_i);
    assign gt = (a_i > b_i);

    always_comb begin
        upd_o = 1'b1;
        val_o = 1'b0;
        unique case (op_i)
            XU_CEQ:  val_o = eq;
            XU_CGT:  val_o = gt;
            XU_CLT:  val_o = !gt && !eq;
            XU_CGE:  val_o = gt || eq;
            XU_CLE:  val_o = !gt;
            XU_CINV: val_o = !flags_i.cf;
            XU_CSET: val_o = 1'b1;
            XU_CCLR: val_o = 1'b0;
            XU_COV:  val_o = flags_i.ov;
            XU_CZF:  val_o = flags_i.zf;
            XU_CCA:  val_o = flags_i.ca;
            default: upd_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/xu16_exec.sv
`timescale 1ns/1ps
module xu16_exec
    import xu16_pkg::*;
#(
    parameter int W = XU_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          valid_i,
    input  logic [4:0]    op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    output logic [W-1:0]  res_a_o,
    output logic [W-1:0]  res_b_o,
    output logic          wr_a_o,
    output logic          wr_b_o,
    output logic          fault_o,
    output logic          zero_o,
    output logic          carry_o,
    output logic          ovf_o,
    output logic          cond_o
);
    typedef struct packed {
        logic [W-1:0] res_a;
        logic [W-1:0] res_b;
        logic         wr_a;
        logic         wr_b;
        logic         fault;
        xu_flags_t    flags;
    } xu_state_t;

    xu_state_t st_d, st_q;
    xu_op_e    op;

    assign op = xu_op_e'(op_i);

    logic [W-1:0] bo_res, ar_res, dv_quo, dv_rem;
    logic         bo_hit, ar_hit, dv_ok, dv_fault;
    xu_flags_t    bo_upd, bo_val, ar_upd, ar_val;
    logic         cd_upd, cd_val;

    xu16_bitops #(.W(W)) i_bitops (
        .op_i (op), .a_i (a_i), .b_i (b_i),
        .res_o (bo_res), .hit_o (bo_hit), .upd_o (bo_upd), .val_o (bo_val)
    );

    xu16_arith #(.W(W)) i_arith (
        .op_i (op), .a_i (a_i), .b_i (b_i),
        .res_o (ar_res), .hit_o (ar_hit), .upd_o (ar_upd), .val_o (ar_val)
    );

    xu16_divider #(.W(W)) i_divider (
        .op_i (op), .a_i (a_i), .b_i (b_i),
        .quo_o (dv_quo), .rem_o (dv_rem), .ok_o (dv_ok), .fault_o (dv_fault)
    );

    xu16_cond #(.W(W)) i_cond (
        .op_i (op), .a_i (a_i), .b_i (b_i), .flags_i (st_q.flags),
        .upd_o (cd_upd), .val_o (cd_val)
    );

    xu_flags_t upd_all, val_all;

    always_comb begin
        upd_all    = bo_upd | ar_upd;
        val_all    = bo_val | ar_val;
        upd_all.cf = cd_upd;
        val_all.cf = cd_val;

        st_d       = st_q;
        st_d.res_a = '0;
        st_d.res_b = '0;
        st_d.wr_a  = 1'b0;
        st_d.wr_b  = 1'b0;
        st_d.fault = 1'b0;
        if (valid_i) begin
            st_d.res_a = bo_res | ar_res | dv_quo;
            st_d.res_b = dv_rem;
            st_d.wr_a  = bo_hit | ar_hit | dv_ok;
            st_d.wr_b  = dv_ok;
            st_d.fault = dv_fault;
            st_d.flags = xu_flags_t'((st_q.flags & ~upd_all) | (val_all & upd_all));
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign res_a_o = st_q.res_a;
    assign res_b_o = st_q.res_b;
    assign wr_a_o  = st_q.wr_a;
    assign wr_b_o  = st_q.wr_b;
    assign fault_o = st_q.fault;
    assign zero_o  = st_q.flags.zf;
    assign carry_o = st_q.flags.ca;
    assign ovf_o   = st_q.flags.ov;
    assign cond_o  = st_q.flags.cf;
endmodule

// File: rtl/xu16_exec_chk.sv
`timescale 1ns/1ps
module xu16_exec_chk
    import xu16_pkg::*;
#(
    parameter int W = XU_W
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          valid_i,
    input logic [4:0]    op_i,
    input logic [W-1:0]  a_i,
    input logic [W-1:0]  b_i,
    input logic [W-1:0]  res_a_o,
    input logic [W-1:0]  res_b_o,
    input logic          wr_a_o,
    input logic          wr_b_o,
    input logic          fault_o,
    input logic          zero_o,
    input logic          carry_o,
    input logic          ovf_o,
    input logic          cond_o
);
    logic is_logic, is_rot, is_cmp;
    assign is_logic = (op_i >= XU_NOT) && (op_i <= XU_NOR);
    assign is_rot   = (op_i == XU_ROR) || (op_i == XU_ROL);
    assign is_cmp   = (op_i >= XU_CEQ) && (op_i <= XU_CLE);

    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !wr_a_o && !wr_b_o && !fault_o && $stable({zero_o, carry_o, ovf_o, cond_o}));

    assert_logic_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && is_logic |=> wr_a_o && $stable({carry_o, ovf_o, cond_o}));

    assert_shl_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && op_i == XU_SHL && b_i[3:0] == 4'd0 |=> !carry_o && res_a_o == $past(a_i));

    assert_rot_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && is_rot |=> $stable({zero_o, carry_o, ovf_o, cond_o}));

    assert_rem_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && op_i == XU_DIV && b_i != '0 |=> wr_b_o && res_b_o < $past(b_i));

    assert_div_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && op_i == XU_DIV && b_i == '0 |=>
            fault_o && !wr_a_o && !wr_b_o && $stable({zero_o, carry_o, ovf_o, cond_o}));

    assert_fault_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> !wr_a_o && !wr_b_o);

    assert_cmp_keep_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i && is_cmp |=> !wr_a_o && $stable({zero_o, carry_o, ovf_o}));
endmodule

bind xu16_exec xu16_exec_chk #(.W(W)) i_xu16_exec_chk (
    .clk_i (clk_i), .rst_ni (rst_ni), .valid_i (valid_i), .op_i (op_i),
    .a_i (a_i), .b_i (b_i), .res_a_o (res_a_o), .res_b_o (res_b_o),
    .wr_a_o (wr_a_o), .wr_b_o (wr_b_o), .fault_o (fault_o),
    .zero_o (zero_o), .carry_o (carry_o), .ovf_o (ovf_o), .cond_o (cond_o)
);

// File: tb/test_xu16_exec.sv
`timescale 1ns/1ps
module test_xu16_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [4:0]  op = '0;
    logic [15:0] a = '0, b = '0;
    logic [15:0] res_a, res_b;
    logic        wr_a, wr_b, fault, zf, ca, ov, cf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model flag state
    logic m_zf = 0, m_ca = 0, m_ov = 0, m_cf = 0;

    always #10 clk = ~clk;

    xu16_exec i_xu16_exec (
        .clk_i (clk), .rst_ni (rst_n), .valid_i (valid), .op_i (op),
        .a_i (a), .b_i (b), .res_a_o (res_a), .res_b_o (res_b),
        .wr_a_o (wr_a), .wr_b_o (wr_b), .fault_o (fault),
        .zero_o (zf), .carry_o (ca), .ovf_o (ov), .cond_o (cf)
    );

    function automatic string req_of(input int o, input logic [15:0] bb, input bit v);
        if (!v || o == 0 || o > 24) return "R2";
        if (o <= 5)  return "R3";
        if (o == 6)  return "R4";
        if (o == 7)  return "R5";
        if (o <= 9)  return "R6";
        if (o == 10) return "R7";
        if (o == 11) return "R8";
        if (o == 12) return "R9";
        if (o == 13) return (bb == 0) ? "R11" : "R10";
        if (o <= 18) return "R12";
        return "R13";
    endfunction

    task automatic check_vec(input string req, input logic [38:0] act, input logic [38:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (ra,rb,wa,wb,flt,zf,ca,ov,cf)", req, act, exp);
        end
    endtask

    task automatic issue(input int o, input logic [15:0] aa, input logic [15:0] bb, input bit v);
        logic [15:0] ea, eb;
        logic        ewa, ewb, ef;
        int          n, s, sa, sb;
        logic [31:0] p;
        ea = 0; eb = 0; ewa = 0; ewb = 0; ef = 0;
        n = int'(bb[3:0]);
        valid = v; op = o[4:0]; a = aa; b = bb;
        if (v) begin
            case (o)
                1: begin ea = ~aa; ewa = 1; m_zf = (ea == 0); end
                2: begin ea = aa & bb; ewa = 1; m_zf = (ea == 0); end
                3: begin ea = aa | bb; ewa = 1; m_zf = (ea == 0); end
                4: begin ea = aa ^ bb; ewa = 1; m_zf = (ea == 0); end
                5: begin ea = ~(aa | bb); ewa = 1; m_zf = (ea == 0); end
                6: begin
                    for (int i = 0; i < 16; i++) ea[i] = (i + n < 16) ? aa[i+n] : 1'b0;
                    ewa = 1; m_zf = (ea == 0);
                end
                7: begin
                    for (int i = 0; i < 16; i++) ea[i] = (i >= n) ? aa[i-n] : 1'b0;
                    ewa = 1; m_zf = (ea == 0); m_ca = (n == 0) ? 1'b0 : aa[16-n];
                end
                8: begin for (int i = 0; i < 16; i++) ea[i] = aa[(i+n)%16]; ewa = 1; end
                9: begin for (int i = 0; i < 16; i++) ea[(i+n)%16] = aa[i]; ewa = 1; end
                10: begin
                    s = int'(aa) + int'(bb); ea = s[15:0]; ewa = 1;
                    sa = $signed(aa); sb = $signed(bb);
                    m_ca = (s > 65535); m_ov = (sa + sb > 32767) || (sa + sb < -32768); m_zf = (ea == 0);
                end
                11: begin
                    s = int'(aa) - int'(bb); ea = s[15:0]; ewa = 1;
                    sa = $signed(aa); sb = $signed(bb);
                    m_ca = (aa < bb); m_ov = (sa - sb > 32767) || (sa - sb < -32768); m_zf = (ea == 0);
                end
                12: begin
                    p = 32'(aa) * 32'(bb); ea = p[15:0]; ewa = 1;
                    m_ca = (p > 32'hFFFF); m_ov = m_ca;
                end
                13: begin
                    if (bb == 0) ef = 1;
                    else begin ea = aa / bb; eb = aa % bb; ewa = 1; ewb = 1; end
                end
                14: m_cf = (aa == bb);
                15: m_cf = (aa > bb);
                16: m_cf = (aa < bb);
                17: m_cf = (aa >= bb);
                18: m_cf = (aa <= bb);
                19: m_cf = ~m_cf;
                20: m_cf = 1;
                21: m_cf = 0;
                22: m_cf = m_ov;
                23: m_cf = m_zf;
                24: m_cf = m_ca;
                default: ;
            endcase
        end
        @(negedge clk);
        check_vec(req_of(o, bb, v), {res_a, res_b, wr_a, wr_b, fault, zf, ca, ov, cf},
                  {ea, eb, ewa, ewb, ef, m_zf, m_ca, m_ov, m_cf});
        valid = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state while held and just after release
        check_vec("R1", {res_a, res_b, wr_a, wr_b, fault, zf, ca, ov, cf}, '0);
        rst_n = 1;
        @(negedge clk);
        check_vec("R1", {res_a, res_b, wr_a, wr_b, fault, zf, ca, ov, cf}, '0);

        // directed corners
        issue(10, 16'hFFFF, 16'h0001, 1);   // R7 carry and zero
        issue(10, 16'h7FFF, 16'h0001, 1);   // R7 overflow, no carry
        issue(11, 16'h0000, 16'h0001, 1);   // R8 borrow
        issue(11, 16'h8000, 16'h0001, 1);   // R8 overflow
        issue(7,  16'h8001, 16'h0001, 1);   // R5 carry from bit 15
        issue(7,  16'h1234, 16'h0010, 1);   // R5 masked count zero
        issue(7,  16'h2000, 16'h0013, 1);   // R5 count 3 via mask
        issue(6,  16'hF000, 16'hFF14, 1);   // R4 masked count 4
        issue(9,  16'h8001, 16'h0001, 1);   // R6
        issue(8,  16'h0000, 16'h0003, 1);   // R6 zero result, zf held
        issue(12, 16'h0100, 16'h0100, 1);   // R9 overflow
        issue(12, 16'h00FF, 16'h0101, 1);   // R9 fits exactly
        issue(13, 16'd100,  16'd7,    1);   // R10
        issue(13, 16'hFFFF, 16'h0000, 1);   // R11 fault
        issue(14, 16'h5555, 16'h5555, 1);   // R12 eq
        issue(15, 16'h5555, 16'h5555, 1);   // R12 gt false
        issue(17, 16'h5555, 16'h5555, 1);   // R12 ge true
        issue(16, 16'h0001, 16'h8000, 1);   // R12 unsigned lt
        issue(19, 16'h0,    16'h0,    1);   // R13 invert
        issue(22, 16'h0,    16'h0,    1);   // R13 copy overflow
        issue(2,  16'hFFFF, 16'h1234, 0);   // R2 valid low
        issue(27, 16'hFFFF, 16'h1234, 1);   // R2 undefined opcode

        for (int k = 0; k < 4000; k++) begin
            int ro;
            logic [15:0] ra, rb;
            bit rv;
            ro = int'($urandom_range(0, 31));
            ra = 16'($urandom);
            rb = ($urandom_range(0, 7) == 0) ? 16'h0 : 16'($urandom);
            rv = ($urandom_range(0, 7) != 0);
            issue(ro, ra, rb, rv);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule